// File: doc/BRIEF.md
# Frame Timing Controller

This block is the sequencing core of a time-division duplex timing engine. Once it is armed and a sync event arrives, it counts a programmable startup delay. It then plays frames of a programmable length, one after another, and stops after a programmed number of frames, or never if that number is zero. During a frame it exposes its position counter, so that downstream comparators can place channel edges relative to the start of the frame. At the last cycle of each frame it raises a one-cycle strobe. It also exports a two-bit state code for a status readout.

The controller has four states. IDLE is the rest state. ARMED waits for sync. WAITING counts the startup delay. RUNNING plays frames. The transitions are:
- arm (IDLE to ARMED) on a rising edge of enable.
- trigger (ARMED to WAITING) on a sync pulse.
- launch (WAITING to RUNNING) when the delay has elapsed.
- complete (RUNNING to IDLE) after the final frame of a counted burst.
- abort (any state to IDLE) whenever enable is low.

When the re-zero option is set, a sync pulse seen in WAITING or RUNNING resets the position counter without changing state. Configuration inputs are expected to stay constant while enable is high.

Top module: `frame_timing_ctrl`

## Requirements
- R1: After reset, state_code is 0 (IDLE), position is 0, running is 0 and frame_end is 0. The state encoding is IDLE=0, ARMED=1, WAITING=2, RUNNING=3.
- R2: IDLE moves to ARMED only in the cycle after enable goes from 0 to 1. Holding enable high after a burst has completed leaves the block in IDLE.
- R3: In ARMED, position stays 0 and the block stays in ARMED until a sync pulse, which moves it to WAITING with position 0.
- R4: WAITING lasts max(startup_delay,1) cycles, with position counting 0, 1, 2 and so on. The block then enters RUNNING with position 0.
- R5: In RUNNING, position counts from 0 up to max(frame_len,1)-1 and then wraps to 0. A frame_len of 0 or 1 gives one-cycle frames, and position stays at 0.
- R6: frame_end is high exactly in the RUNNING cycles where position equals max(frame_len,1)-1, enable is high, and no re-zeroing sync is present.
- R7: With burst_total N>0, the block returns to IDLE in the cycle after the N-th frame_end. With burst_total 0 it keeps running indefinitely.
- R8: In WAITING or RUNNING, a sync pulse with sync_rezero=1 sets position to 0 in the next cycle and keeps the state. This takes precedence over delay expiry and frame end: no frame_end strobe fires and no frame is counted.
- R9: A sync pulse with sync_rezero=0 has no effect in WAITING or RUNNING. A sync pulse in IDLE has no effect.
- R10: enable low in any state gives IDLE with position 0 in the next cycle, and clears the frame count, so the next burst plays its full length.
- R11: running is 1 exactly when state_code is 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Run enable; a rising edge arms, low aborts |
| sync_pulse | input | 1 | Combined sync event, one cycle per event |
| sync_rezero | input | 1 | Sync re-zeroes the position counter while timing |
| startup_delay | input | CNT_W | Delay cycles between trigger and first frame |
| frame_len | input | CNT_W | Cycles per frame |
| burst_total | input | BURST_W | Frames per burst, 0 for endless |
| running | output | 1 | High while in RUNNING |
| position | output | CNT_W | Current delay or frame position counter |
| frame_end | output | 1 | One-cycle strobe on the last cycle of a frame |
| state_code | output | 2 | Current state code |

## Verification
Two events can fall in the same cycle: a re-zeroing sync can coincide with the last cycle of a frame, or with the last cycle of the startup delay. The bench provokes both collisions directly. It places a sync with re-zero on the final cycle of the single frame of a one-frame burst, and on the final delay cycle. It then checks that the block stays in RUNNING or WAITING with position 0 and that no strobe fires. Random stimulus, with rare syncs and short frames, hits further collisions. Every cycle is judged against a bench model in which the re-zero takes precedence.

// File: rtl/ftc_pkg.sv
package ftc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ARMED   = 2'd1,
        ST_WAITING = 2'd2,
        ST_RUNNING = 2'd3
    } ftc_state_e;

endpackage

// File: rtl/ftc_pos_counter.sv
module ftc_pos_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    input  logic [CNT_W-1:0] delay_len,
    input  logic [CNT_W-1:0] frame_len,
    output logic [CNT_W-1:0] count,
    output logic             delay_done,
    output logic             frame_last
);
    localparam int EXT_W = CNT_W + 1;

    logic [EXT_W-1:0] count_plus;

    assign count_plus = {1'b0, count} + EXT_W'(1);

    // A programmed length of zero behaves like one.
    assign delay_done = count_plus >= {1'b0, delay_len};
    assign frame_last = count_plus >= {1'b0, frame_len};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (inc) begin
            count <= count_plus[CNT_W-1:0];
        end
    end

endmodule

// File: rtl/ftc_burst_tracker.sv
module ftc_burst_tracker #(
    parameter int BURST_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               inc,
    input  logic [BURST_W-1:0] burst_total,
    output logic               final_frame
);
    localparam int EXT_W = BURST_W + 1;

    logic [BURST_W-1:0] frames_done;
    logic [EXT_W-1:0]   frames_plus;

    assign frames_plus = {1'b0, frames_done} + EXT_W'(1);

    // Zero total selects endless operation.
    assign final_frame = (burst_total != '0) && (frames_plus == {1'b0, burst_total});

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frames_done <= '0;
        end else if (clr) begin
            frames_done <= '0;
        end else if (inc) begin
            frames_done <= frames_plus[BURST_W-1:0];
        end
    end

endmodule

// File: rtl/ftc_sequencer.sv
module ftc_sequencer
    import ftc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic       sync_pulse,
    input  logic       sync_rezero,
    input  logic       delay_done,
    input  logic       frame_last,
    input  logic       final_frame,
    output ftc_state_e state,
    output logic       pos_clr,
    output logic       pos_inc,
    output logic       burst_clr,
    output logic       burst_inc,
    output logic       frame_end
);
    ftc_state_e state_nxt;
    logic       enable_q;
    logic       arm_edge;
    logic       rezero;

    assign arm_edge = enable && !enable_q;
    assign rezero   = sync_pulse && sync_rezero;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            enable_q <= 1'b0;
        end else begin
            state    <= state_nxt;
            enable_q <= enable;
        end
    end

    // Transitions and counter actions
    always_comb begin
        state_nxt = state;
        pos_clr   = 1'b0;
        pos_inc   = 1'b0;
        burst_clr = 1'b0;
        burst_inc = 1'b0;
        if (!enable) begin
            state_nxt = ST_IDLE;
            pos_clr   = 1'b1;
            burst_clr = 1'b1;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    pos_clr   = 1'b1;
                    burst_clr = 1'b1;
                    if (arm_edge) state_nxt = ST_ARMED;
                end
                ST_ARMED: begin
                    pos_clr = 1'b1;
                    if (sync_pulse) state_nxt = ST_WAITING;
                end
                ST_WAITING: begin
                    if (rezero) begin
                        pos_clr = 1'b1;
                    end else if (delay_done) begin
                        pos_clr   = 1'b1;
                        state_nxt = ST_RUNNING;
                    end else begin
                        pos_inc = 1'b1;
                    end
                end
                ST_RUNNING: begin
                    if (rezero) begin
                        pos_clr = 1'b1;
                    end else if (frame_last) begin
                        pos_clr   = 1'b1;
                        burst_inc = 1'b1;
                        if (final_frame) begin
                            burst_clr = 1'b1;
                            state_nxt = ST_IDLE;
                        end
                    end else begin
                        pos_inc = 1'b1;
                    end
                end
                default: state_nxt = ST_IDLE;
            endcase
        end
    end

    // Output strobe
    always_comb begin
        frame_end = enable && (state == ST_RUNNING) && frame_last && !rezero;
    end

endmodule

// File: rtl/frame_timing_ctrl.sv
module frame_timing_ctrl
    import ftc_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter int BURST_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic               sync_pulse,
    input  logic               sync_rezero,
    input  logic [CNT_W-1:0]   startup_delay,
    input  logic [CNT_W-1:0]   frame_len,
    input  logic [BURST_W-1:0] burst_total,
    output logic               running,
    output logic [CNT_W-1:0]   position,
    output logic               frame_end,
    output logic [1:0]         state_code
);
    ftc_state_e state;
    logic       pos_clr, pos_inc, burst_clr, burst_inc;
    logic       delay_done, frame_last, final_frame;

    ftc_sequencer seq_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .sync_pulse  (sync_pulse),
        .sync_rezero (sync_rezero),
        .delay_done  (delay_done),
        .frame_last  (frame_last),
        .final_frame (final_frame),
        .state       (state),
        .pos_clr     (pos_clr),
        .pos_inc     (pos_inc),
        .burst_clr   (burst_clr),
        .burst_inc   (burst_inc),
        .frame_end   (frame_end)
    );

    ftc_pos_counter #(.CNT_W(CNT_W)) pos_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (pos_clr),
        .inc        (pos_inc),
        .delay_len  (startup_delay),
        .frame_len  (frame_len),
        .count      (position),
        .delay_done (delay_done),
        .frame_last (frame_last)
    );

    ftc_burst_tracker #(.BURST_W(BURST_W)) burst_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr         (burst_clr),
        .inc         (burst_inc),
        .burst_total (burst_total),
        .final_frame (final_frame)
    );

    assign running    = (state == ST_RUNNING);
    assign state_code = state;

endmodule

// File: rtl/frame_timing_ctrl_checker.sv
module frame_timing_ctrl_checker #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic             sync_pulse,
    input logic             sync_rezero,
    input logic             running,
    input logic [CNT_W-1:0] position,
    input logic             frame_end,
    input logic [1:0]       state_code
);
    assert_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (state_code == 2'd0) && (position == '0));

    assert_armed_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && state_code == 2'd1 && !sync_pulse) |=> (state_code == 2'd1) && (position == '0));

    assert_rezero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && sync_pulse && sync_rezero && state_code[1])
        |=> (position == '0) && (state_code == $past(state_code)));

    assert_strobe_running_R6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |-> running);

    assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (running && enable && !frame_end && !(sync_pulse && sync_rezero))
        |=> running && (position == $past(position) + 1'b1));

    assert_wait_exit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && state_code == 2'd2) |=> state_code[1]);

endmodule

bind frame_timing_ctrl frame_timing_ctrl_checker #(.CNT_W(CNT_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .sync_pulse  (sync_pulse),
    .sync_rezero (sync_rezero),
    .running     (running),
    .position    (position),
    .frame_end   (frame_end),
    .state_code  (state_code)
);

// File: tb/frame_timing_ctrl_tb_top.sv
`timescale 1ns/1ps
module frame_timing_ctrl_tb_top;
    localparam int CNT_W   = 32;
    localparam int BURST_W = 32;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               en = 1'b0, sy = 1'b0, sr = 1'b0;
    logic [CNT_W-1:0]   dl = '0, fl = '0;
    logic [BURST_W-1:0] bt = '0;
    logic               running, frame_end;
    logic [CNT_W-1:0]   position;
    logic [1:0]         state_code;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    // Bench model
    int      m_st = 0;
    longint  m_cnt = 0;
    longint  m_frames = 0;
    bit      m_enq = 0;

    always #5 clk = ~clk;

    frame_timing_ctrl #(.CNT_W(CNT_W), .BURST_W(BURST_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .enable(en), .sync_pulse(sy), .sync_rezero(sr),
        .startup_delay(dl), .frame_len(fl), .burst_total(bt),
        .running(running), .position(position), .frame_end(frame_end),
        .state_code(state_code)
    );

    function automatic bit last_of_frame();
        return (m_cnt + 1) >= longint'(fl);
    endfunction

    function automatic bit exp_strobe();
        return en && m_st == 3 && !(sy && sr) && last_of_frame();
    endfunction

    task automatic check(string req, longint act, longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic void model_step();
        bit rz = sy && sr;
        if (!en) begin
            m_st = 0; m_cnt = 0; m_frames = 0;
        end else begin
            case (m_st)
                0: begin m_cnt = 0; m_frames = 0; if (!m_enq) m_st = 1; end
                1: begin m_cnt = 0; if (sy) m_st = 2; end
                2: begin
                    if (rz) m_cnt = 0;
                    else if (m_cnt + 1 >= longint'(dl)) begin m_cnt = 0; m_st = 3; end
                    else m_cnt++;
                end
                default: begin
                    if (rz) m_cnt = 0;
                    else if (last_of_frame()) begin
                        m_cnt = 0;
                        m_frames++;
                        if (bt != 0 && m_frames == longint'(bt)) begin
                            m_st = 0; m_frames = 0;
                        end
                    end else m_cnt++;
                end
            endcase
        end
        m_enq = en;
    endfunction

    // One clock: drive, compare with model before the edge, advance model.
    task automatic cyc(bit e, bit s, bit r);
        en = e; sy = s; sr = r;
        #1;
        check("R3 state", state_code, m_st);
        check("R5 position", position, m_cnt);
        check("R11 running", running, m_st == 3);
        check("R6 frame_end", frame_end, exp_strobe());
        @(posedge clk);
        model_step();
        @(negedge clk);
    endtask

    task automatic cfg(int d, int f, int b);
        dl = CNT_W'(d); fl = CNT_W'(f); bt = BURST_W'(b);
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        check("R1 state", state_code, 0);
        check("R1 position", position, 0);
        check("R1 running", running, 0);
        check("R1 frame_end", frame_end, 0);
        @(negedge clk);

        // Delay 3, frame 4, two frames
        cfg(3, 4, 2);
        cyc(0, 0, 0);
        cyc(1, 0, 0);
        check("R2 armed", state_code, 1);
        cyc(1, 0, 0); cyc(1, 0, 0);
        check("R3 armed hold", state_code, 1);
        cyc(1, 1, 0);
        check("R3 trigger", state_code, 2);
        cyc(1, 0, 0); cyc(1, 0, 0);
        check("R4 waiting pos", position, 2);
        cyc(1, 0, 0);
        check("R4 launch", state_code, 3);
        check("R4 launch pos", position, 0);
        repeat (4) cyc(1, 0, 0);
        check("R5 wrap", position, 0);
        check("R7 mid burst", state_code, 3);
        repeat (4) cyc(1, 0, 0);
        check("R7 burst done", state_code, 0);
        repeat (3) cyc(1, 1, 1);
        check("R2 no rearm", state_code, 0);
        check("R9 sync in idle", position, 0);

        // Re-zero and ignored sync
        cfg(2, 6, 0);
        cyc(0, 0, 0); cyc(1, 0, 0); cyc(1, 1, 0);
        cyc(1, 0, 0); cyc(1, 0, 0);
        cyc(1, 0, 0); cyc(1, 0, 0);
        check("R5 running pos", position, 2);
        cyc(1, 1, 1);
        check("R8 rezero pos", position, 0);
        check("R8 rezero state", state_code, 3);
        cyc(1, 0, 0);
        cyc(1, 1, 0);
        check("R9 ignored sync", position, 2);
        cyc(0, 0, 0);
        check("R10 abort state", state_code, 0);
        check("R10 abort pos", position, 0);

        // Zero-length frames, endless
        cfg(0, 0, 0);
        cyc(1, 0, 0); cyc(1, 1, 0); cyc(1, 0, 0);
        check("R4 zero delay", state_code, 3);
        repeat (20) cyc(1, 0, 0);
        check("R7 endless", state_code, 3);
        check("R5 one-cycle frame", position, 0);
        cyc(0, 0, 0);

        // Rezero collides with final frame end and with delay expiry
        cfg(2, 3, 1);
        cyc(1, 0, 0); cyc(1, 1, 0);
        cyc(1, 0, 0);
        cyc(1, 1, 1);
        check("R8 delay collision", state_code, 2);
        cyc(1, 0, 0); cyc(1, 0, 0);
        cyc(1, 0, 0); cyc(1, 0, 0);
        check("R5 pos before end", position, 2);
        cyc(1, 1, 1);
        check("R8 frame collision state", state_code, 3);
        check("R8 frame collision pos", position, 0);
        repeat (3) cyc(1, 0, 0);
        check("R7 single frame done", state_code, 0);
        cyc(0, 0, 0);

        // Random phase
        for (int i = 0; i < 4000; i++) begin
            bit e, s, r;
            if (!en && ($urandom % 3 == 0))
                cfg(int'($urandom % 6), int'($urandom % 7), int'($urandom % 4));
            e = ($urandom % 40) != 0;
            s = ($urandom % 9) == 0;
            r = ($urandom % 2) == 0;
            cyc(e, s, r);
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule